// File: doc/BRIEF.md
# AEAD Encrypt-Then-MAC Sequencer

This block orders the work of an authenticated-encryption construction. Two engines outside it do the heavy lifting. One is a keystream generator that returns one 64-byte block for a key, a 64-bit nonce and a 64-bit block counter. The other is a one-time MAC engine that is loaded with a 32-byte key, fed 16-byte chunks and asked for a 16-byte tag. The sequencer talks to both through simple request/response ports. For each message it does the following, in order:

1. Fetches keystream block 0 and loads the MAC engine with the low 32 bytes of that block.
2. Streams the additional data into the MAC.
3. XORs the payload with keystream taken from block 1 onward.
4. Authenticates the ciphertext.
5. Closes the MAC input with 8-byte little-endian length fields.

The nonce is the 64-bit record sequence number, supplied whole with each message; no nonce bytes travel with the data.

In encrypt mode the sequencer emits the ciphertext followed directly by the 16-byte tag. In decrypt mode it emits the plaintext, takes the 16 received tag bytes after the ciphertext, compares all of them, and then raises one authentication-failure flag on any mismatch. A message is started with a single handshake that carries the key, nonce, mode and both lengths. Additional-data bytes, then payload bytes (and in decrypt mode the tag bytes) follow one per accepted cycle on a valid/ready byte input.

Top module: `aead_seq`

## Requirements
- R1: After reset `start_ready` is 1 and `out_valid`, `done`, `auth_fail`, `ks_req_valid` and `mac_req_valid` are 0. A start is accepted only while `start_ready` is 1, and `start_ready` is 0 from the cycle after acceptance until the message has finished.
- R2: The first keystream request of a message carries counter 0 and the message's key and nonce. The MAC engine is then loaded with the INIT op (`mac_req_op` = 1), with `mac_req_key` byte i (bits 8i+7..8i) equal to byte i of that block for i = 0..31. Block bytes 32..63 are not used.
- R3: Payload keystream is requested with counters 1, 2, 3, ..., one block per 64 payload bytes (ceil(len/64) requests). No payload request is made for an empty payload. A request is held with a stable counter until accepted.
- R4: Payload byte i is combined by XOR with byte (i mod 64) of keystream block 1 + i/64, where byte j of a block is bits 8j+7..8j of `ks_rsp_block`.
- R5: The bytes given to the MAC are, in order and with no padding: the additional data, its length as 8 little-endian bytes, the ciphertext (the input in decrypt mode, the XOR result in encrypt mode), and the ciphertext length as 8 little-endian bytes.
- R6: MAC bytes travel in CHUNK ops (`mac_req_op` = 2), with chunk byte k at bits 8k+7..8k of `mac_req_data` and the byte count in `mac_req_len`. Every chunk holds 16 bytes except the last, which holds 1..16. A stalled chunk is held stable. A FINAL op (`mac_req_op` = 3) follows the last chunk.
- R7: In encrypt mode the output is the ciphertext bytes with `out_tag` = 0, then 16 tag bytes with `out_tag` = 1, where tag byte k is bits 8k+7..8k of `mac_tag`.
- R8: In decrypt mode the output is the plaintext bytes, and no tag bytes are emitted. After the payload, 16 tag bytes are consumed from the input in the same byte order. `auth_fail` is 1 exactly when any of the 16 differs, is set together with `done`, and holds until the next start. In encrypt mode `auth_fail` is 0.
- R9: Empty additional data and empty payload are legal. Their length fields are then eight zero bytes and are still authenticated.
- R10: `done` pulses for one cycle, one cycle after the last tag byte has been emitted or consumed. `start_ready` returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request for a message |
| start_ready | output | 1 | Sequencer idle, start will be accepted |
| start_decrypt | input | 1 | 1 = decrypt and verify, 0 = encrypt |
| start_key | input | 256 | Cipher key |
| start_nonce | input | 64 | Nonce (record sequence number) |
| start_aad_len | input | 16 | Additional-data length in bytes |
| start_msg_len | input | 16 | Payload length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid (one cycle each) |
| out_data | output | 8 | Output byte |
| out_tag | output | 1 | Output byte is a tag byte |
| done | output | 1 | Message finished pulse |
| auth_fail | output | 1 | Tag mismatch on the last decrypt |
| ks_req_valid | output | 1 | Keystream block request |
| ks_req_ready | input | 1 | Keystream request accepted |
| ks_req_key | output | 256 | Key for the request |
| ks_req_nonce | output | 64 | Nonce for the request |
| ks_req_ctr | output | 64 | Block counter for the request |
| ks_rsp_valid | input | 1 | Keystream block returned |
| ks_rsp_block | input | 512 | Keystream block |
| mac_req_valid | output | 1 | MAC operation request |
| mac_req_ready | input | 1 | MAC operation accepted |
| mac_req_op | output | 2 | 1 INIT, 2 CHUNK, 3 FINAL |
| mac_req_key | output | 256 | MAC key for INIT |
| mac_req_data | output | 128 | Chunk bytes |
| mac_req_len | output | 5 | Chunk byte count |
| mac_tag_valid | input | 1 | Tag returned |
| mac_tag | input | 128 | Computed tag |

## Verification
Every cycle, the assertions check several properties:
- no output byte appears while the sequencer is idle;
- tag bytes appear only in encrypt mode;
- a chunk never collides with an INIT or FINAL op;
- stalled chunks and keystream requests stay stable;
- chunk lengths are never zero;
- a mismatching received tag byte always leaves the compare flag set.

The bench's scenarios are needed for the rest, each checked against models computed in the bench:
- the key taken from block 0;
- the order of counters;
- the exact MAC byte stream, including both length fields, with chunking across field boundaries under MAC back-pressure;
- the XOR data;
- the tag placement;
- the verify outcome for good and corrupted tags.

// File: rtl/aead_seq_pkg.sv
package aead_seq_pkg;

    typedef enum logic [1:0] {
        MAC_NOP   = 2'd0,
        MAC_INIT  = 2'd1,
        MAC_CHUNK = 2'd2,
        MAC_FINAL = 2'd3
    } mac_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_K0_REQ,
        ST_K0_WAIT,
        ST_MINIT,
        ST_AAD,
        ST_ALEN,
        ST_KREQ,
        ST_KWAIT,
        ST_MSG,
        ST_CLEN,
        ST_FLUSH,
        ST_FINAL,
        ST_TAGW,
        ST_EMIT,
        ST_CHECK,
        ST_DONE
    } seq_st_e;

endpackage

// File: rtl/aead_mac_packer.sv
module aead_mac_packer #(
    parameter int CHUNK_BYTES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      byte_valid,
    input  logic [7:0]                byte_data,
    output logic                      byte_ready,
    input  logic                      flush,
    output logic                      idle,
    output logic                      chk_valid,
    input  logic                      chk_ready,
    output logic [CHUNK_BYTES*8-1:0]  chk_data,
    output logic [$clog2(CHUNK_BYTES+1)-1:0] chk_len
);
    localparam int CW    = CHUNK_BYTES * 8;
    localparam int CNT_W = $clog2(CHUNK_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHUNK_BYTES - 1);

    typedef struct packed {
        logic [CW-1:0]    buf_;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } pk_t;

    pk_t q, d;

    always_comb begin
        d          = q;
        byte_ready = !q.pend;
        chk_valid  = q.pend;
        chk_data   = q.buf_;
        chk_len    = q.cnt;
        idle       = !q.pend && (q.cnt == '0);
        if (q.pend) begin
            if (chk_ready) begin
                d.pend = 1'b0;
                d.cnt  = '0;
                d.buf_ = '0;
            end
        end else if (byte_valid) begin
            d.buf_[{q.cnt, 3'b000} +: 8] = byte_data;
            d.cnt = q.cnt + CNT_W'(1);
            if (q.cnt == LAST) begin
                d.pend = 1'b1;
            end
        end else if (flush && (q.cnt != '0)) begin
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R6
    chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_ready) |=> (chk_valid && $stable(chk_data) && $stable(chk_len)));

    // R6
    chunk_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> (chk_len != '0));

endmodule

// File: rtl/aead_tag_cmp.sv
module aead_tag_cmp #(
    parameter int TAG_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          byte_valid,
    input  logic [$clog2(TAG_BYTES)-1:0]  idx,
    input  logic [7:0]                    rx_byte,
    input  logic [TAG_BYTES*8-1:0]        tag,
    output logic                          mismatch
);
    logic [7:0] diff_d, diff_q;
    logic [7:0] ref_byte;

    always_comb begin
        ref_byte = tag[{idx, 3'b000} +: 8];
        diff_d   = diff_q;
        if (clr) begin
            diff_d = '0;
        end else if (byte_valid) begin
            diff_d = diff_q | (rx_byte ^ ref_byte);
        end
        mismatch = (diff_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q <= '0;
        end else begin
            diff_q <= diff_d;
        end
    end

    // R8
    sticky_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !clr && (rx_byte != tag[{idx, 3'b000} +: 8])) |=> mismatch);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !mismatch);

endmodule

// File: rtl/aead_seq.sv
module aead_seq
    import aead_seq_pkg::*;
#(
    parameter int KEY_W       = 256,
    parameter int NONCE_W     = 64,
    parameter int CTR_W       = 64,
    parameter int LEN_W       = 16,
    parameter int BLOCK_BYTES = 64,
    parameter int CHUNK_BYTES = 16,
    parameter int TAG_BYTES   = 16,
    parameter int MKEY_BYTES  = 32,
    parameter int LENF_BYTES  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    output logic                               start_ready,
    input  logic                               start_decrypt,
    input  logic [KEY_W-1:0]                   start_key,
    input  logic [NONCE_W-1:0]                 start_nonce,
    input  logic [LEN_W-1:0]                   start_aad_len,
    input  logic [LEN_W-1:0]                   start_msg_len,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [7:0]                         in_data,
    output logic                               out_valid,
    output logic [7:0]                         out_data,
    output logic                               out_tag,
    output logic                               done,
    output logic                               auth_fail,
    output logic                               ks_req_valid,
    input  logic                               ks_req_ready,
    output logic [KEY_W-1:0]                   ks_req_key,
    output logic [NONCE_W-1:0]                 ks_req_nonce,
    output logic [CTR_W-1:0]                   ks_req_ctr,
    input  logic                               ks_rsp_valid,
    input  logic [BLOCK_BYTES*8-1:0]           ks_rsp_block,
    output logic                               mac_req_valid,
    input  logic                               mac_req_ready,
    output logic [1:0]                         mac_req_op,
    output logic [MKEY_BYTES*8-1:0]            mac_req_key,
    output logic [CHUNK_BYTES*8-1:0]           mac_req_data,
    output logic [$clog2(CHUNK_BYTES+1)-1:0]   mac_req_len,
    input  logic                               mac_tag_valid,
    input  logic [TAG_BYTES*8-1:0]             mac_tag
);
    localparam int BLK_W  = BLOCK_BYTES * 8;
    localparam int TAG_W  = TAG_BYTES * 8;
    localparam int MKEY_W = MKEY_BYTES * 8;
    localparam int LENF_W = LENF_BYTES * 8;
    localparam int BIDX_W = $clog2(BLOCK_BYTES);
    localparam int TIDX_W = $clog2(TAG_BYTES);
    localparam int IDX_W  = $clog2((TAG_BYTES > LENF_BYTES) ? TAG_BYTES : LENF_BYTES);
    localparam logic [BIDX_W-1:0] BLK_LAST  = BIDX_W'(BLOCK_BYTES - 1);
    localparam logic [IDX_W-1:0]  LENF_LAST = IDX_W'(LENF_BYTES - 1);
    localparam logic [IDX_W-1:0]  TAG_LAST  = IDX_W'(TAG_BYTES - 1);

    typedef struct packed {
        seq_st_e             st;
        logic                dec;
        logic [KEY_W-1:0]    key;
        logic [NONCE_W-1:0]  nonce;
        logic [LEN_W-1:0]    alen;
        logic [LEN_W-1:0]    plen;
        logic [LEN_W-1:0]    cnt;
        logic [CTR_W-1:0]    ctr;
        logic [BLK_W-1:0]    ks;
        logic [BIDX_W-1:0]   bidx;
        logic [IDX_W-1:0]    sub;
        logic [TAG_W-1:0]    tag;
        logic                out_valid;
        logic                out_tag;
        logic [7:0]          out_data;
        logic                done;
        logic                auth;
    } seq_t;

    seq_t q, d;

    logic        pk_valid, pk_ready, pk_flush, pk_idle;
    logic [7:0]  pk_byte;
    logic        pk_chk_valid;
    logic [CHUNK_BYTES*8-1:0] pk_chk_data;
    logic [$clog2(CHUNK_BYTES+1)-1:0] pk_chk_len;
    logic        tc_clr, tc_valid, tc_mismatch;
    mac_op_e     op_w;

    logic [LENF_W-1:0] alen_f, plen_f;
    logic [7:0]        ks_byte, xor_byte;
    logic [LEN_W-1:0]  cnt_inc;

    assign alen_f   = LENF_W'(q.alen);
    assign plen_f   = LENF_W'(q.plen);
    assign ks_byte  = q.ks[{q.bidx, 3'b000} +: 8];
    assign xor_byte = in_data ^ ks_byte;
    assign cnt_inc  = q.cnt + LEN_W'(1);

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.out_tag   = 1'b0;
        d.done      = 1'b0;
        pk_valid    = 1'b0;
        pk_byte     = '0;
        pk_flush    = 1'b0;
        in_ready    = 1'b0;
        tc_clr      = 1'b0;
        tc_valid    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.dec   = start_decrypt;
                    d.key   = start_key;
                    d.nonce = start_nonce;
                    d.alen  = start_aad_len;
                    d.plen  = start_msg_len;
                    d.ctr   = '0;
                    d.auth  = 1'b0;
                    tc_clr  = 1'b1;
                    d.st    = ST_K0_REQ;
                end
            end
            ST_K0_REQ: if (ks_req_ready) d.st = ST_K0_WAIT;
            ST_K0_WAIT: begin
                if (ks_rsp_valid) begin
                    d.ks = ks_rsp_block;
                    d.st = ST_MINIT;
                end
            end
            ST_MINIT: begin
                if (mac_req_ready) begin
                    d.cnt = '0;
                    d.sub = '0;
                    d.st  = (q.alen == '0) ? ST_ALEN : ST_AAD;
                end
            end
            ST_AAD: begin
                in_ready = pk_ready;
                pk_valid = in_valid;
                pk_byte  = in_data;
                if (in_valid && pk_ready) begin
                    d.cnt = cnt_inc;
                    if (cnt_inc == q.alen) d.st = ST_ALEN;
                end
            end
            ST_ALEN: begin
                pk_valid = 1'b1;
                pk_byte  = alen_f[{q.sub, 3'b000} +: 8];
                if (pk_ready) begin
                    d.sub = q.sub + IDX_W'(1);
                    if (q.sub == LENF_LAST) begin
                        d.sub = '0;
                        d.cnt = '0;
                        if (q.plen == '0) begin
                            d.st = ST_CLEN;
                        end else begin
                            d.ctr = CTR_W'(1);
                            d.st  = ST_KREQ;
                        end
                    end
                end
            end
            ST_KREQ: if (ks_req_ready) d.st = ST_KWAIT;
            ST_KWAIT: begin
                if (ks_rsp_valid) begin
                    d.ks   = ks_rsp_block;
                    d.bidx = '0;
                    d.st   = ST_MSG;
                end
            end
            ST_MSG: begin
                in_ready = pk_ready;
                pk_valid = in_valid;
                pk_byte  = q.dec ? in_data : xor_byte;
                if (in_valid && pk_ready) begin
                    d.out_valid = 1'b1;
                    d.out_data  = xor_byte;
                    d.cnt       = cnt_inc;
                    d.bidx      = q.bidx + BIDX_W'(1);
                    if (cnt_inc == q.plen) begin
                        d.sub = '0;
                        d.st  = ST_CLEN;
                    end else if (q.bidx == BLK_LAST) begin
                        d.ctr = q.ctr + CTR_W'(1);
                        d.st  = ST_KREQ;
                    end
                end
            end
            ST_CLEN: begin
                pk_valid = 1'b1;
                pk_byte  = plen_f[{q.sub, 3'b000} +: 8];
                if (pk_ready) begin
                    d.sub = q.sub + IDX_W'(1);
                    if (q.sub == LENF_LAST) begin
                        d.sub = '0;
                        d.st  = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: begin
                pk_flush = 1'b1;
                if (pk_idle) d.st = ST_FINAL;
            end
            ST_FINAL: if (mac_req_ready) d.st = ST_TAGW;
            ST_TAGW: begin
                if (mac_tag_valid) begin
                    d.tag = mac_tag;
                    d.sub = '0;
                    d.st  = q.dec ? ST_CHECK : ST_EMIT;
                end
            end
            ST_EMIT: begin
                d.out_valid = 1'b1;
                d.out_tag   = 1'b1;
                d.out_data  = q.tag[{q.sub, 3'b000} +: 8];
                d.sub       = q.sub + IDX_W'(1);
                if (q.sub == TAG_LAST) d.st = ST_DONE;
            end
            ST_CHECK: begin
                in_ready = 1'b1;
                tc_valid = in_valid;
                if (in_valid) begin
                    d.sub = q.sub + IDX_W'(1);
                    if (q.sub == TAG_LAST) d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                d.done = 1'b1;
                d.auth = q.dec & tc_mismatch;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    aead_mac_packer #(.CHUNK_BYTES(CHUNK_BYTES)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (pk_valid),
        .byte_data  (pk_byte),
        .byte_ready (pk_ready),
        .flush      (pk_flush),
        .idle       (pk_idle),
        .chk_valid  (pk_chk_valid),
        .chk_ready  (mac_req_ready),
        .chk_data   (pk_chk_data),
        .chk_len    (pk_chk_len)
    );

    aead_tag_cmp #(.TAG_BYTES(TAG_BYTES)) u_tag_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tc_clr),
        .byte_valid (tc_valid),
        .idx        (q.sub[TIDX_W-1:0]),
        .rx_byte    (in_data),
        .tag        (q.tag),
        .mismatch   (tc_mismatch)
    );

    always_comb begin
        if (q.st == ST_MINIT)       op_w = MAC_INIT;
        else if (q.st == ST_FINAL)  op_w = MAC_FINAL;
        else if (pk_chk_valid)      op_w = MAC_CHUNK;
        else                        op_w = MAC_NOP;
    end

    assign start_ready   = (q.st == ST_IDLE);
    assign ks_req_valid  = (q.st == ST_K0_REQ) || (q.st == ST_KREQ);
    assign ks_req_key    = q.key;
    assign ks_req_nonce  = q.nonce;
    assign ks_req_ctr    = q.ctr;
    assign mac_req_valid = (op_w != MAC_NOP);
    assign mac_req_op    = op_w;
    assign mac_req_key   = q.ks[MKEY_W-1:0];
    assign mac_req_data  = pk_chk_data;
    assign mac_req_len   = pk_chk_len;
    assign out_valid     = q.out_valid;
    assign out_data      = q.out_data;
    assign out_tag       = q.out_tag;
    assign done          = q.done;
    assign auth_fail     = q.auth;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> (!out_valid && !ks_req_valid && !mac_req_valid));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> start_ready);

    // R7
    tag_enc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag) |-> !q.dec);

    // R6
    mac_op_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_chk_valid |-> ((q.st != ST_MINIT) && (q.st != ST_FINAL)));

    // R3
    ks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_req_valid && !ks_req_ready) |=> (ks_req_valid && $stable(ks_req_ctr)));

    // R8
    auth_dec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auth_fail |-> q.dec);

endmodule

// File: tb/aead_seq_tb.sv
module aead_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         start, start_ready, start_decrypt;
    logic [255:0] start_key;
    logic [63:0]  start_nonce;
    logic [15:0]  start_aad_len, start_msg_len;
    logic         in_valid, in_ready;
    logic [7:0]   in_data;
    logic         out_valid, out_tag, done, auth_fail;
    logic [7:0]   out_data;
    logic         ks_req_valid, ks_req_ready;
    logic [255:0] ks_req_key;
    logic [63:0]  ks_req_nonce, ks_req_ctr;
    logic         ks_rsp_valid;
    logic [511:0] ks_rsp_block;
    logic         mac_req_valid, mac_req_ready;
    logic [1:0]   mac_req_op;
    logic [255:0] mac_req_key;
    logic [127:0] mac_req_data;
    logic [4:0]   mac_req_len;
    logic         mac_tag_valid;
    logic [127:0] mac_tag;

    aead_seq u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ksb(input logic [255:0] k, input logic [63:0] n,
                                       input logic [63:0] c, input int i);
        logic [31:0] x;
        x = k[31:0] ^ k[255:224] ^ k[127:96] ^ n[31:0] ^ (n[63:32] * 32'd3)
            ^ (c[31:0] * 32'h9E3779B9) ^ (32'(i) * 32'h85EBCA6B);
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 12);
        x = x * 32'h297A2D39;
        return x[7:0] ^ x[23:16];
    endfunction

    function automatic logic [511:0] ks_block(input logic [255:0] k, input logic [63:0] n,
                                              input logic [63:0] c);
        logic [511:0] b;
        for (int i = 0; i < 64; i++) b[i*8 +: 8] = ksb(k, n, c, i);
        return b;
    endfunction

    function automatic logic [127:0] mac_fn(input logic [255:0] k, input logic [7:0] s[$]);
        logic [127:0] h;
        h = k[127:0];
        foreach (s[i]) begin
            h = {h[119:0], h[127:120]} ^ {120'd0, s[i]};
            h = h + k[255:128] + 128'(i);
        end
        return h ^ k[255:128];
    endfunction

    // models' records
    logic [63:0]  ks_ctrs[$];
    logic [255:0] seen_mkey;
    logic [7:0]   mac_s[$];
    int           chunk_err;
    int           final_cnt;
    bit           short_seen;
    logic [8:0]   out_q[$];

    // keystream generator model
    initial begin
        ks_req_ready = 1'b1;
        ks_rsp_valid = 1'b0;
        ks_rsp_block = '0;
        forever begin
            @(negedge clk);
            if (ks_req_valid) begin
                logic [63:0] c;
                logic [255:0] k;
                logic [63:0] n;
                c = ks_req_ctr; k = ks_req_key; n = ks_req_nonce;
                ks_ctrs.push_back(c);
                repeat (1 + $urandom % 3) @(negedge clk);
                ks_rsp_block = ks_block(k, n, c);
                ks_rsp_valid = 1'b1;
                @(negedge clk);
                ks_rsp_valid = 1'b0;
                ks_rsp_block = '0;
            end
        end
    end

    // MAC engine model
    initial begin
        mac_req_ready = 1'b0;
        mac_tag_valid = 1'b0;
        mac_tag = '0;
        forever begin
            @(negedge clk);
            mac_req_ready = ($urandom % 4) != 0;
            if (mac_req_valid && mac_req_ready) begin
                if (mac_req_op == 2'd1) begin
                    seen_mkey = mac_req_key;
                    mac_s.delete();
                    short_seen = 1'b0;
                end else if (mac_req_op == 2'd2) begin
                    if (short_seen || mac_req_len == 0 || mac_req_len > 16) chunk_err++;
                    if (mac_req_len != 16) short_seen = 1'b1;
                    for (int i = 0; i < 16; i++)
                        if (i < int'(mac_req_len)) mac_s.push_back(mac_req_data[i*8 +: 8]);
                end else if (mac_req_op == 2'd3) begin
                    final_cnt++;
                    repeat (1 + $urandom % 3) @(negedge clk);
                    mac_tag = mac_fn(seen_mkey, mac_s);
                    mac_tag_valid = 1'b1;
                    @(negedge clk);
                    mac_tag_valid = 1'b0;
                end
            end
        end
    end

    // output monitor
    initial forever begin
        @(negedge clk);
        if (out_valid) out_q.push_back({out_tag, out_data});
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    logic [7:0] aad_a[0:255];
    logic [7:0] pt_a[0:255];
    logic [7:0] ct_a[0:255];
    int alen, plen;

    task automatic feed(input logic [7:0] b);
        if ($urandom % 4 == 0) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_data = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_msg(input bit dec, input bit corrupt, input string name);
        logic [255:0] key;
        logic [63:0]  nonce;
        logic [511:0] b0;
        logic [7:0]   exp_s[$];
        logic [8:0]   exp_o[$];
        logic [127:0] etag, rtag;
        int nb, bad, to;
        key   = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        nonce = {$urandom, $urandom};
        b0    = ks_block(key, nonce, 64'd0);
        for (int i = 0; i < plen; i++) ct_a[i] = pt_a[i] ^ ksb(key, nonce, 64'(1 + i / 64), i % 64);
        for (int i = 0; i < alen; i++) exp_s.push_back(aad_a[i]);
        for (int i = 0; i < 8; i++) exp_s.push_back(8'(64'(alen) >> (8 * i)));
        for (int i = 0; i < plen; i++) exp_s.push_back(ct_a[i]);
        for (int i = 0; i < 8; i++) exp_s.push_back(8'(64'(plen) >> (8 * i)));
        etag = mac_fn(b0[255:0], exp_s);
        rtag = etag;
        if (corrupt) rtag[($urandom % 16) * 8 +: 8] ^= 8'h5A;
        for (int i = 0; i < plen; i++) exp_o.push_back({1'b0, dec ? pt_a[i] : ct_a[i]});
        if (!dec) for (int i = 0; i < 16; i++) exp_o.push_back({1'b1, etag[i*8 +: 8]});
        ks_ctrs.delete();
        out_q.delete();
        chunk_err = 0;
        final_cnt = 0;

        start_decrypt = dec; start_key = key; start_nonce = nonce;
        start_aad_len = 16'(alen); start_msg_len = 16'(plen);
        start = 1'b1;
        #1;
        while (!start_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        start = 1'b0;
        chk(start_ready == 1'b0, "R1", {name, " start_ready busy"}, 256'(start_ready), 256'd0);

        for (int i = 0; i < alen; i++) feed(aad_a[i]);
        for (int i = 0; i < plen; i++) feed(dec ? ct_a[i] : pt_a[i]);
        if (dec) for (int i = 0; i < 16; i++) feed(rtag[i*8 +: 8]);
        to = 0;
        while (!done && to < 3000) begin @(negedge clk); to++; end
        chk(done == 1'b1 && start_ready == 1'b1, "R10", {name, " done with start_ready"},
            256'({done, start_ready}), 256'd3);
        chk(auth_fail == corrupt, "R8", {name, " auth_fail"}, 256'(auth_fail), 256'(corrupt));

        nb = (plen + 63) / 64;
        bad = (ks_ctrs.size() != nb + 1);
        foreach (ks_ctrs[i]) if (ks_ctrs[i] != 64'(i)) bad++;
        chk(bad == 0 && ks_ctrs.size() > 0 && ks_ctrs[0] == 0, "R2", {name, " counter 0 first"},
            256'(ks_ctrs.size()), 256'(nb + 1));
        chk(bad == 0, "R3", {name, " payload counters"}, 256'(ks_ctrs.size()), 256'(nb + 1));
        chk(seen_mkey == b0[255:0], "R2", {name, " mac key"}, seen_mkey, b0[255:0]);
        bad = (mac_s.size() != exp_s.size());
        foreach (exp_s[i]) if (i < mac_s.size() && mac_s[i] != exp_s[i]) bad++;
        chk(bad == 0, (alen == 0 || plen == 0) ? "R9" : "R5", {name, " mac stream"},
            256'(mac_s.size()), 256'(exp_s.size()));
        chk(chunk_err == 0 && final_cnt == 1, "R6", {name, " chunking"},
            256'({chunk_err, final_cnt}), 256'(1));
        bad = (out_q.size() != exp_o.size());
        foreach (exp_o[i]) if (i < out_q.size() && out_q[i] != exp_o[i]) bad++;
        chk(bad == 0, dec ? "R8" : (plen == 0 ? "R7" : "R4"), {name, " output bytes"},
            256'(out_q.size()), 256'(exp_o.size()));
        if (!dec) begin
            bad = 0;
            for (int i = 0; i < 16; i++)
                if (out_q.size() != exp_o.size() || out_q[plen + i] != {1'b1, etag[i*8 +: 8]}) bad++;
            chk(bad == 0, "R7", {name, " tag after ciphertext"}, 256'(bad), 256'd0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", {name, " done one cycle"}, 256'(done), 256'd0);
        chk(auth_fail == corrupt, "R8", {name, " auth_fail held"}, 256'(auth_fail), 256'(corrupt));
    endtask

    task automatic fill(input int a, input int p);
        alen = a;
        plen = p;
        for (int i = 0; i < a; i++) aad_a[i] = 8'($urandom);
        for (int i = 0; i < p; i++) pt_a[i] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        start = 0; start_decrypt = 0; start_key = '0; start_nonce = '0;
        start_aad_len = '0; start_msg_len = '0; in_valid = 0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(start_ready == 1'b1, "R1", "reset start_ready", 256'(start_ready), 256'd1);
        chk({out_valid, done, auth_fail} == 3'b000, "R1", "reset outputs",
            256'({out_valid, done, auth_fail}), 256'd0);
        chk({ks_req_valid, mac_req_valid} == 2'b00, "R1", "reset requests",
            256'({ks_req_valid, mac_req_valid}), 256'd0);

        fill(0, 0);    run_msg(1'b0, 1'b0, "enc empty");       // R9
        fill(0, 0);    run_msg(1'b1, 1'b0, "dec empty");       // R9
        fill(0, 0);    run_msg(1'b1, 1'b1, "dec empty bad");   // R8
        fill(16, 64);  run_msg(1'b0, 1'b0, "enc block edge");  // R3 R6
        fill(5, 65);   run_msg(1'b1, 1'b1, "dec over edge bad");
        fill(3, 128);  run_msg(1'b0, 1'b0, "enc two blocks");
        fill(20, 1);   run_msg(1'b1, 1'b0, "dec one byte");
        fill(0, 7);    run_msg(1'b0, 1'b0, "enc no aad");
        fill(9, 0);    run_msg(1'b0, 1'b0, "enc no payload");
        for (int r = 0; r < 10; r++) begin
            bit dec;
            dec = 1'($urandom % 2);
            fill($urandom % 41, $urandom % 150);
            run_msg(dec, dec && ($urandom % 3 == 0), "random");
        end
        summary();
        $finish;
    end
endmodule